// File: doc/BRIEF.md
# Prefetch Sequence Reconstruction Engine

This engine turns one slice of a recorded history of spatial-region trigger misses into a short, ordered list of prefetch addresses. After a `start` pulse it takes in a stream of trigger records, oldest first, beginning with the matched record. Each record carries a region number, a pattern key and a delta: the number of accesses that came between the previous trigger and this one. From these the engine builds a timeline of `SLOTS` positions in two passes.

In the first pass, which runs while the records arrive, each record's region base address goes into its own slot. The slots are spaced by the deltas. In the second pass the engine reads the pattern table once for each record it kept. For every confident element of a hit, it places a block address at the element's learned slot distance from the record's slot. If that slot is taken, it tries nearby slots in a fixed order. Last, it scans the timeline in slot order and hands out each filled slot on a valid/ready stream, then pulses `done`.

Storage and training of the pattern table sit outside the block. The table is reached through a combinational read port, and the table treats each read strobe as a use for its replacement state.

Top module: `sre_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `rec_ready`, `pt_rd_en`, `out_valid` and `done` are all low.
- R2: Every slot starts a run empty, marked by the all-ones address. An empty slot is never presented on the output.
- R3: The first record goes to slot 0. Each later record goes to the previous kept record's slot plus its own `rec_delta` plus one. The slot receives the region base, `rec_region * REGION_BYTES`, which is the region number with zero low offset bits. The first record's delta is ignored.
- R4: If a record's computed slot is `SLOTS` or more, the walk ends. That record and every later record of the run are still accepted, up to the one flagged `rec_last`, but they are discarded: they are not placed and not looked up.
- R5: Once the record marked `rec_last` has been accepted, the engine strobes `pt_rd_en` exactly once for each kept record, in arrival order, with that record's key on `pt_rd_key`.
- R6: A table hit returns `ELEMS` elements on `pt_rd_elems`. Element e sits at bits [e*EW +: EW] with EW = 2 + EDLT_W + OFS_W. Inside an element, the offset is in the low OFS_W bits, the slot distance is in the next EDLT_W bits, and the 2-bit confidence counter is in the top two bits. Only elements whose counter is 2 or 3 produce an address, and that address is the region base plus the offset.
- R7: Confident elements are placed in element order, one record at a time. The target slot is the record's slot plus the element's distance. If the target is taken, the engine tries target+1, then target+2, then target−1, then target−2, skipping any candidate outside 0..SLOTS−1. If all are taken, the address is dropped. A slot filled by the first pass or by an earlier placement is never overwritten.
- R8: The filled slots are presented in increasing slot order with `out_valid`/`out_addr`. `out_addr` holds steady while `out_ready` is low.
- R9: One cycle after the last slot has been scanned, `done` is high for exactly one cycle, and after that `busy` is low. A `start` that arrives while `busy` is high has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reconstruction run (sampled while idle) |
| busy | output | 1 | A run is in progress |
| rec_valid | input | 1 | Trigger record valid |
| rec_ready | output | 1 | Engine accepts a record |
| rec_region | input | ADDR_W-OFS_W | Spatial region number |
| rec_key | input | KEY_W | Pattern table key of the record |
| rec_delta | input | DLT_W | Accesses since the previous trigger |
| rec_last | input | 1 | This is the final record of the run |
| pt_rd_en | output | 1 | Pattern table read strobe |
| pt_rd_key | output | KEY_W | Pattern table read key |
| pt_rd_hit | input | 1 | Key found in the pattern table |
| pt_rd_elems | input | ELEMS*EW | Packed pattern elements of the hit |
| out_valid | output | 1 | Prefetch address valid |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | ADDR_W | Prefetch address |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Runs with only misses in the table isolate the spacing of region bases: one record on its own, a spaced chain of three, and a chain that runs off the end of the timeline, which shows that records after the cutoff stay discarded even when their delta would fit. A single hit carrying all four counter values separates the confident elements from the ignored ones. Two crowded timelines make placement fall through +1, +2, −1 and −2, fail at the array bounds, and drop an element. A stalling consumer, together with a stray `start` during loading, shows that order and address hold under back-pressure and that the run cannot be restarted.

// File: rtl/sre_pkg.sv
`timescale 1ns/1ps
package sre_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LOAD  = 3'd1,
        PH_LOOK  = 3'd2,
        PH_PLACE = 3'd3,
        PH_EMIT  = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    // Number of candidate positions tried for one placement
    localparam int PICK_TRIES = 5;

    // Signed distance of candidate k from the target: +0,+1,+2,-1,-2
    function automatic int pick_step(input int k);
        return (k < 3) ? k : (2 - k);
    endfunction

endpackage

// File: rtl/sre_slot_pick.sv
`timescale 1ns/1ps
module sre_slot_pick
    import sre_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int TW    = 6,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0] occ,
    input  logic [TW-1:0]    target,
    output logic             found,
    output logic [IDX_W-1:0] pick
);

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < PICK_TRIES; k++) begin
            int cand;
            cand = int'(target) + pick_step(k);
            if (!found && cand >= 0 && cand < SLOTS) begin
                if (!occ[IDX_W'(cand)]) begin
                    found = 1'b1;
                    pick  = IDX_W'(cand);
                end
            end
        end
    end

endmodule

// File: rtl/sre_rec_store.sv
`timescale 1ns/1ps
module sre_rec_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/sre_engine.sv
`timescale 1ns/1ps
module sre_engine
    import sre_pkg::*;
#(
    parameter int SLOTS        = 16,
    parameter int ADDR_W       = 32,
    parameter int REGION_BYTES = 256,
    parameter int KEY_W        = 16,
    parameter int DLT_W        = 8,
    parameter int EDLT_W       = 4,
    parameter int ELEMS        = 4,
    localparam int OFS_W  = $clog2(REGION_BYTES),
    localparam int REG_W  = ADDR_W - OFS_W,
    localparam int EW     = 2 + EDLT_W + OFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  busy,
    input  logic                  rec_valid,
    output logic                  rec_ready,
    input  logic [REG_W-1:0]      rec_region,
    input  logic [KEY_W-1:0]      rec_key,
    input  logic [DLT_W-1:0]      rec_delta,
    input  logic                  rec_last,
    output logic                  pt_rd_en,
    output logic [KEY_W-1:0]      pt_rd_key,
    input  logic                  pt_rd_hit,
    input  logic [ELEMS*EW-1:0]   pt_rd_elems,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [ADDR_W-1:0]     out_addr,
    output logic                  done
);

    localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W  = IDX_W + 1;
    localparam int EPT_W  = (ELEMS > 1) ? $clog2(ELEMS) : 1;
    localparam int SW     = ((IDX_W > DLT_W) ? IDX_W : DLT_W) + 2;
    localparam int TW     = ((IDX_W > EDLT_W) ? IDX_W : EDLT_W) + 1;
    localparam int RW     = REG_W + KEY_W + IDX_W;

    typedef struct packed {
        phase_e                          phase;
        logic [SLOTS-1:0][ADDR_W-1:0]    slot;
        logic [IDX_W-1:0]                idx;
        logic [CNT_W-1:0]                nrec;
        logic                            first;
        logic                            stop;
        logic [IDX_W-1:0]                rptr;
        logic [ELEMS*EW-1:0]             elems;
        logic [EPT_W-1:0]                eptr;
        logic [IDX_W-1:0]                scan;
    } st_t;

    function automatic st_t rst_state();
        st_t r;
        r       = '0;
        r.phase = PH_IDLE;
        r.slot  = '1;
        return r;
    endfunction

    st_t s_d, s_q;

    // record store ports
    logic              st_wr_en;
    logic [IDX_W-1:0]  st_wr_idx;
    logic [RW-1:0]     st_wr_data;
    logic [RW-1:0]     st_rd_data;
    logic [REG_W-1:0]  cur_region;
    logic [KEY_W-1:0]  cur_key;
    logic [IDX_W-1:0]  cur_base;

    // placement
    logic [SLOTS-1:0]  occ;
    logic [EW-1:0]     cur_el;
    logic [1:0]        cur_ctr;
    logic [EDLT_W-1:0] cur_edl;
    logic [OFS_W-1:0]  cur_ofs;
    logic [TW-1:0]     pick_target;
    logic              pick_ok;
    logic [IDX_W-1:0]  pick_idx;

    logic [SW-1:0]     nxt_slot;
    logic              last_rec;

    generate
        for (genvar gi = 0; gi < SLOTS; gi++) begin : g_occ
            assign occ[gi] = (s_q.slot[gi] != {ADDR_W{1'b1}});
        end
    endgenerate

    sre_rec_store #(
        .DEPTH (SLOTS),
        .W     (RW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_data (st_wr_data),
        .rd_idx  (s_q.rptr),
        .rd_data (st_rd_data)
    );

    assign {cur_region, cur_key, cur_base} = st_rd_data;

    assign cur_el      = s_q.elems[int'(s_q.eptr) * EW +: EW];
    assign cur_ctr     = cur_el[EW-1 -: 2];
    assign cur_edl     = cur_el[OFS_W +: EDLT_W];
    assign cur_ofs     = cur_el[OFS_W-1:0];
    assign pick_target = TW'(cur_base) + TW'(cur_edl);

    sre_slot_pick #(
        .SLOTS (SLOTS),
        .TW    (TW)
    ) u_pick (
        .occ    (occ),
        .target (pick_target),
        .found  (pick_ok),
        .pick   (pick_idx)
    );

    assign nxt_slot = s_q.first ? '0
                    : SW'(s_q.idx) + SW'(rec_delta) + SW'(1);
    assign last_rec = ({1'b0, s_q.rptr} + CNT_W'(1)) == s_q.nrec;

    always_comb begin
        s_d        = s_q;
        st_wr_en   = 1'b0;
        st_wr_idx  = s_q.nrec[IDX_W-1:0];
        st_wr_data = {rec_region, rec_key, nxt_slot[IDX_W-1:0]};
        rec_ready  = 1'b0;
        pt_rd_en   = 1'b0;
        pt_rd_key  = cur_key;
        out_valid  = 1'b0;
        out_addr   = s_q.slot[s_q.scan];
        done       = 1'b0;

        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.slot  = '1;
                    s_d.nrec  = '0;
                    s_d.idx   = '0;
                    s_d.first = 1'b1;
                    s_d.stop  = 1'b0;
                    s_d.phase = PH_LOAD;
                end
            end

            PH_LOAD: begin
                rec_ready = 1'b1;
                if (rec_valid) begin
                    s_d.first = 1'b0;
                    if (!s_q.stop) begin
                        if (nxt_slot < SW'(SLOTS)) begin
                            st_wr_en = 1'b1;
                            s_d.slot[nxt_slot[IDX_W-1:0]] =
                                {rec_region, {OFS_W{1'b0}}};
                            s_d.idx  = nxt_slot[IDX_W-1:0];
                            s_d.nrec = s_q.nrec + CNT_W'(1);
                        end else begin
                            s_d.stop = 1'b1;
                        end
                    end
                    if (rec_last) begin
                        s_d.rptr  = '0;
                        s_d.phase = PH_LOOK;
                    end
                end
            end

            PH_LOOK: begin
                pt_rd_en = 1'b1;
                if (pt_rd_hit) begin
                    s_d.elems = pt_rd_elems;
                    s_d.eptr  = '0;
                    s_d.phase = PH_PLACE;
                end else if (last_rec) begin
                    s_d.scan  = '0;
                    s_d.phase = PH_EMIT;
                end else begin
                    s_d.rptr  = s_q.rptr + IDX_W'(1);
                end
            end

            PH_PLACE: begin
                if (cur_ctr > 2'd1 && pick_ok) begin
                    s_d.slot[pick_idx] = {cur_region, cur_ofs};
                end
                if (s_q.eptr == EPT_W'(ELEMS - 1)) begin
                    if (last_rec) begin
                        s_d.scan  = '0;
                        s_d.phase = PH_EMIT;
                    end else begin
                        s_d.rptr  = s_q.rptr + IDX_W'(1);
                        s_d.phase = PH_LOOK;
                    end
                end else begin
                    s_d.eptr = s_q.eptr + EPT_W'(1);
                end
            end

            PH_EMIT: begin
                out_valid = occ[s_q.scan];
                if (!occ[s_q.scan] || out_ready) begin
                    if (s_q.scan == IDX_W'(SLOTS - 1)) begin
                        s_d.phase = PH_DONE;
                    end else begin
                        s_d.scan = s_q.scan + IDX_W'(1);
                    end
                end
            end

            PH_DONE: begin
                done      = 1'b1;
                s_d.phase = PH_IDLE;
            end

            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= rst_state();
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.phase != PH_IDLE);

endmodule

// File: rtl/sre_engine_chk.sv
`timescale 1ns/1ps
module sre_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rec_ready,
    input logic              pt_rd_en,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              done
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rec_ready && !pt_rd_en && !out_valid && !done));

    assert_no_empty_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr != {ADDR_W{1'b1}}));

    assert_lookup_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |-> (busy && !rec_ready && !out_valid));

    assert_hold_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && !pt_rd_en && !rec_ready));

endmodule

bind sre_engine sre_engine_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rec_ready (rec_ready),
    .pt_rd_en  (pt_rd_en),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .done      (done)
);

// File: tb/sre_engine_test.sv
`timescale 1ns/1ps
module sre_engine_test;

    localparam int EW = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [23:0] rec_region = '0;
    logic [15:0] rec_key = '0;
    logic [7:0]  rec_delta = '0;
    logic        rec_last = 1'b0;
    logic        pt_rd_en;
    logic [15:0] pt_rd_key;
    logic        pt_rd_hit;
    logic [4*EW-1:0] pt_rd_elems;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic        done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // stimulus description
    int          nr;
    logic [23:0] r_reg [8];
    logic [15:0] r_key [8];
    logic [7:0]  r_dl  [8];
    logic        tk_v   [4];
    logic [15:0] tk_key [4];
    logic [4*EW-1:0] tk_el [4];

    // expectations
    logic [31:0] exp_addr [16];
    int          exp_n;
    logic [15:0] exp_key [16];
    int          exp_nk;

    always #5 clk = ~clk;

    sre_engine uut (
        .clk (clk), .rst_n (rst_n), .start (start), .busy (busy),
        .rec_valid (rec_valid), .rec_ready (rec_ready),
        .rec_region (rec_region), .rec_key (rec_key),
        .rec_delta (rec_delta), .rec_last (rec_last),
        .pt_rd_en (pt_rd_en), .pt_rd_key (pt_rd_key),
        .pt_rd_hit (pt_rd_hit), .pt_rd_elems (pt_rd_elems),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_addr (out_addr), .done (done)
    );

    // pattern table model
    always_comb begin
        pt_rd_hit   = 1'b0;
        pt_rd_elems = '0;
        for (int i = 0; i < 4; i++) begin
            if (tk_v[i] && tk_key[i] == pt_rd_key) begin
                pt_rd_hit   = 1'b1;
                pt_rd_elems = tk_el[i];
            end
        end
    end

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
        end
    endtask

    function automatic logic [EW-1:0] el(input int ctr, input int dl, input int ofs);
        return {2'(ctr), 4'(dl), 8'(ofs)};
    endfunction

    task automatic clear_setup();
        nr = 0;
        for (int i = 0; i < 4; i++) begin
            tk_v[i] = 1'b0; tk_key[i] = '0; tk_el[i] = '0;
        end
    endtask

    task automatic add_rec(input int region, input int key, input int dl);
        r_reg[nr] = 24'(region); r_key[nr] = 16'(key); r_dl[nr] = 8'(dl);
        nr++;
    endtask

    // Expected result built from the requirements
    task automatic build_expected();
        logic [31:0] sl [16];
        int base [16];
        int kept;
        int idx;
        int nxt;
        bit stop;
        for (int i = 0; i < 16; i++) sl[i] = 32'hFFFF_FFFF;
        kept = 0; idx = 0; stop = 0; exp_nk = 0; exp_n = 0;
        for (int r = 0; r < nr; r++) begin
            nxt = (r == 0) ? 0 : idx + int'(r_dl[r]) + 1;       // R3
            if (!stop) begin
                if (nxt < 16) begin
                    sl[nxt] = {r_reg[r], 8'h00};
                    base[kept] = nxt;
                    exp_key[kept] = r_key[r];
                    kept++;
                    idx = nxt;
                end else stop = 1;                               // R4
            end
        end
        exp_nk = kept;
        for (int j = 0; j < kept; j++) begin                     // R5
            int t_i;
            t_i = -1;
            for (int i = 0; i < 4; i++)
                if (tk_v[i] && tk_key[i] == exp_key[j]) t_i = i;
            if (t_i >= 0) begin
                for (int e = 0; e < 4; e++) begin
                    logic [EW-1:0] x;
                    x = tk_el[t_i][e*EW +: EW];
                    if (x[13:12] > 2'd1) begin                   // R6
                        int t;
                        int steps [5];
                        bit placed;
                        steps = '{0, 1, 2, -1, -2};              // R7
                        t = base[j] + int'(x[11:8]);
                        placed = 0;
                        for (int k = 0; k < 5; k++) begin
                            int c;
                            c = t + steps[k];
                            if (!placed && c >= 0 && c < 16 && sl[c] == 32'hFFFF_FFFF) begin
                                sl[c] = {sl[base[j]][31:8], x[7:0]};
                                placed = 1;
                            end
                        end
                    end
                end
            end
        end
        for (int i = 0; i < 16; i++)
            if (sl[i] != 32'hFFFF_FFFF) begin
                exp_addr[exp_n] = sl[i];
                exp_n++;
            end
    endtask

    task automatic run_case(input string tag, input bit bp, input bit poke_start);
        logic [31:0] got [32];
        logic [15:0] keys [32];
        int got_n;
        int nk;
        int guard;
        bit seen_done;
        build_expected();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < nr; i++) begin
            rec_valid = 1'b1; rec_region = r_reg[i]; rec_key = r_key[i];
            rec_delta = r_dl[i]; rec_last = (i == nr - 1);
            if (poke_start && i == 1) start = 1'b1;
            #1;
            guard = 0;
            while (!rec_ready && guard < 50) begin
                @(negedge clk); #1; guard++;
            end
            @(negedge clk);
            start = 1'b0;
        end
        rec_valid = 1'b0; rec_last = 1'b0;
        got_n = 0; nk = 0; seen_done = 0; guard = 0;
        while (!seen_done && guard < 3000) begin
            out_ready = bp ? ((guard % 3) != 2) : 1'b1;
            #1;
            if (pt_rd_en && nk < 32) begin keys[nk] = pt_rd_key; nk++; end
            if (out_valid && out_ready && got_n < 32) begin got[got_n] = out_addr; got_n++; end
            if (done) seen_done = 1;
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b1;
        chk(seen_done, "R9", {tag, " done pulse seen"}, 32'(seen_done), 32'd1);
        chk(!busy, "R9", {tag, " idle after done"}, 32'(busy), 32'd0);
        chk(nk == exp_nk, "R5", {tag, " lookup count"}, 32'(nk), 32'(exp_nk));
        for (int i = 0; i < nk && i < exp_nk; i++)
            chk(keys[i] == exp_key[i], "R5", {tag, " lookup key"}, 32'(keys[i]), 32'(exp_key[i]));
        chk(got_n == exp_n, tag, "prefetch count", 32'(got_n), 32'(exp_n));
        for (int i = 0; i < got_n && i < exp_n; i++)
            chk(got[i] == exp_addr[i], tag, "prefetch address (R8 order)", got[i], exp_addr[i]);
    endtask

    task automatic t_reset();
        #1;
        chk(!busy && !rec_ready && !pt_rd_en && !out_valid && !done, "R1",
            "quiet outputs after reset",
            {27'd0, busy, rec_ready, pt_rd_en, out_valid, done}, 32'd0);
    endtask

    task automatic t_single_miss();
        clear_setup();
        add_rec(24'h000012, 16'h0011, 9);
        run_case("R2", 0, 0);
    endtask

    task automatic t_spacing();
        clear_setup();
        add_rec(24'h000100, 16'h0101, 0);
        add_rec(24'h000200, 16'h0102, 2);
        add_rec(24'h000300, 16'h0103, 1);
        run_case("R3", 0, 1);   // stray start during load: R9
    endtask

    task automatic t_overflow();
        clear_setup();
        add_rec(24'h000A00, 16'h0201, 0);
        add_rec(24'h000A01, 16'h0202, 5);
        add_rec(24'h000A02, 16'h0203, 5);
        add_rec(24'h000A03, 16'h0204, 3);
        add_rec(24'h000A04, 16'h0205, 0);
        run_case("R4", 0, 0);
    endtask

    task automatic t_confidence();
        clear_setup();
        add_rec(24'h000040, 16'h0022, 0);
        tk_v[0] = 1'b1; tk_key[0] = 16'h0022;
        tk_el[0] = {el(0, 7, 8'h40), el(1, 6, 8'h30), el(2, 4, 8'h20), el(3, 2, 8'h10)};
        run_case("R6", 0, 0);
    endtask

    task automatic t_fallback_hi();
        clear_setup();
        add_rec(24'h000080, 16'h0055, 0);
        add_rec(24'h000081, 16'h0066, 13);
        tk_v[0] = 1'b1; tk_key[0] = 16'h0055;
        tk_el[0] = {el(3, 13, 8'h05), el(3, 0, 8'h03), el(3, 0, 8'h02), el(3, 0, 8'h01)};
        tk_v[1] = 1'b1; tk_key[1] = 16'h0066;
        tk_el[1] = {el(2, 15, 8'h10), el(3, 0, 8'h0C), el(3, 1, 8'h08), el(3, 1, 8'h04)};
        run_case("R7", 0, 0);
    endtask

    task automatic t_fallback_lo_bp();
        clear_setup();
        add_rec(24'h000090, 16'h0077, 0);
        add_rec(24'h000091, 16'h0078, 2);
        add_rec(24'h000092, 16'h0079, 0);
        add_rec(24'h000093, 16'h007A, 0);
        tk_v[0] = 1'b1; tk_key[0] = 16'h0077;
        tk_el[0] = {el(0, 0, 0), el(0, 0, 0), el(3, 9, 8'h09), el(3, 3, 8'h07)};
        run_case("R8", 1, 0);
    endtask

    initial begin
        clear_setup();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_miss();
        t_spacing();
        t_overflow();
        t_confidence();
        t_fallback_hi();
        t_fallback_lo_bp();
        summary_and_end();
    end

endmodule